// File: doc/BRIEF.md
# Packed-to-Zoned Decimal Stream Converter

This block turns a packed-decimal number into its zoned-decimal form as a byte stream. A packed number arrives one byte at a time, most significant digit first. Each byte carries two 4-bit digit codes, and a sign code ends the number. The block emits one byte per decimal digit. Every digit byte except the last is the digit's ASCII character. In the last digit byte, the sign replaces the upper (zone) nibble. The sign never appears as a byte of its own, so the output length always equals the digit count.

Both sides use a valid/ready handshake with a last-byte marker. An input byte moves only on a cycle where `in_valid` and `in_ready` are both high. An output byte moves only on a cycle where `out_valid` and `out_ready` are both high. When the consumer holds `out_ready` low, the output byte stays frozen. The converter then stops and pulls `in_ready` low until it can go on. A digit is only known to be the last one when the next code turns out to be the sign. For that reason, one digit is always held back until the code after it has been seen. A sticky error flag reports a bad digit code, a bad sign code, or a number that has no digits. The stream is still drained to its end when an error occurs.

Top module: `pz_convert`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `err` is 0.
- R2: Every output byte except the last of a number has upper nibble 0x3 and the digit in its lower nibble. Digits leave in input order, most significant first.
- R3: The last output byte of a number has `out_last` = 1, and only that byte does. Its upper nibble is 0xC when the sign code is 0xC, 0xD when the sign code is 0xD, and 0x3 when the sign code is 0xF. Its lower nibble is the last digit.
- R4: With the sign in the low nibble of the final byte, input 53 84 2C yields 35 33 38 34 C2. A single byte 7D yields D7.
- R5: When the high nibble of the final input byte is a sign code (C, D or F), that nibble is the sign and the low nibble is padding that produces nothing. Input 60 71 D0 yields 36 30 37 D1.
- R6: In a number of more than one byte, a zero high nibble in the first byte is a pad and produces no output. Input 01 23 4F yields 31 32 33 34. In a one-byte number the high nibble is always a digit, so input 0C yields C0.
- R7: A digit code above 9, or a sign code other than C, D or F, sets `err`. All remaining bytes are still converted. A bad digit is emitted in the low nibble as it is. A bad sign gives zone 0x3 on the last byte.
- R8: A number whose only byte has a sign code in its high nibble (for example C0) has no digits. It sets `err` and emits no byte.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values and `out_valid` stays 1. No byte is lost or repeated under any stall pattern.
- R10: Input bytes offered with gaps in `in_valid`, or while `in_ready` is low, are each converted exactly once.
- R11: `err` stays set after a faulty number ends. It clears when the first code of the next number is processed, unless that number also has a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packed byte offered |
| in_ready | output | 1 | Converter can take the offered byte |
| in_data | input | 8 | Packed byte: high nibble first, then low nibble |
| in_last | input | 1 | Offered byte is the final byte of the number |
| out_valid | output | 1 | Zoned byte offered |
| out_ready | input | 1 | Consumer takes the offered byte |
| out_data | output | 8 | Zoned byte: zone or sign in the upper nibble, digit in the lower nibble |
| out_last | output | 1 | Offered byte is the final digit byte and carries the sign |
| err | output | 1 | Sticky flag: bad digit, bad sign or no digits in the current or most recent number |

## Verification
The assertions check the following on every cycle:
- A stalled output byte stays frozen.
- Every non-final byte carries zone 0x3.
- A final byte carries zone 0x3, 0xC or 0xD.
- A non-final byte whose digit field is above 9 always comes with `err` raised.

The directed scenarios show the behaviour that depends on a whole number:
- the exact byte sequence and placement of `out_last` for each sign position;
- dropping of the leading and trailing pad nibbles;
- the empty number;
- that `err` survives the end of a faulty number and is cleared by the next number.

The scenarios run under output stalls and input gaps, which shows that no byte is lost or repeated.

// File: rtl/pz_pkg.sv
package pz_pkg;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] ZONE_DIGIT = 4'h3;
  localparam logic [NIB_W-1:0] SIGN_PLUS = 4'hC;
  localparam logic [NIB_W-1:0] SIGN_MINUS = 4'hD;
  localparam logic [NIB_W-1:0] SIGN_NONE = 4'hF;
  localparam logic [NIB_W-1:0] DIGIT_MAX = 4'h9;

  typedef enum logic [1:0] {
    NK_DIGIT = 2'd0,
    NK_SIGN  = 2'd1,
    NK_PAD   = 2'd2
  } nib_kind_e;

  function automatic logic is_sign_code(input logic [NIB_W-1:0] n);
    return (n == SIGN_PLUS) || (n == SIGN_MINUS) || (n == SIGN_NONE);
  endfunction

  // Zone nibble placed on the final digit byte for a given sign code.
  function automatic logic [NIB_W-1:0] zone_for_sign(input logic [NIB_W-1:0] n);
    logic [NIB_W-1:0] z;
    if (n == SIGN_PLUS) z = SIGN_PLUS;
    else if (n == SIGN_MINUS) z = SIGN_MINUS;
    else z = ZONE_DIGIT;
    return z;
  endfunction
endpackage

// File: rtl/pz_byte_hold.sv
// Holds one accepted packed byte and walks its two nibbles, high first.
module pz_byte_hold
  import pz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              advance,
  output logic              in_ready,
  output logic              hold_v,
  output logic              hold_lo,
  output logic [BYTE_W-1:0] hold_byte,
  output logic              hold_last,
  output logic              hold_first
);
  logic first_pend;
  logic in_fire;

  // A new byte may enter while the low nibble of the held one retires.
  assign in_ready = !hold_v || (hold_lo && advance);
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v     <= 1'b0;
      hold_lo    <= 1'b0;
      hold_byte  <= '0;
      hold_last  <= 1'b0;
      hold_first <= 1'b0;
      first_pend <= 1'b1;
    end else if (in_fire) begin
      hold_v     <= 1'b1;
      hold_lo    <= 1'b0;
      hold_byte  <= in_data;
      hold_last  <= in_last;
      hold_first <= first_pend;
      first_pend <= in_last;
    end else if (advance) begin
      if (hold_lo) hold_v <= 1'b0;
      else hold_lo <= 1'b1;
    end
  end
endmodule

// File: rtl/pz_nib_classify.sv
// Decides what the current nibble of the held byte means.
module pz_nib_classify
  import pz_pkg::*;
(
  input  logic              hold_lo,
  input  logic [BYTE_W-1:0] hold_byte,
  input  logic              hold_last,
  input  logic              hold_first,
  output logic [NIB_W-1:0]  nib,
  output nib_kind_e         kind,
  output logic              first_nib
);
  logic [NIB_W-1:0] hi_n;
  logic [NIB_W-1:0] lo_n;
  logic             hi_is_sign;

  assign hi_n       = hold_byte[BYTE_W-1:NIB_W];
  assign lo_n       = hold_byte[NIB_W-1:0];
  assign hi_is_sign = hold_last && is_sign_code(hi_n);
  assign nib        = hold_lo ? lo_n : hi_n;
  assign first_nib  = hold_first && !hold_lo;

  always_comb begin
    if (!hold_lo) begin
      if (hold_first && !hold_last && (hi_n == '0)) kind = NK_PAD;
      else if (hi_is_sign) kind = NK_SIGN;
      else kind = NK_DIGIT;
    end else begin
      if (!hold_last) kind = NK_DIGIT;
      else if (hi_is_sign) kind = NK_PAD;
      else kind = NK_SIGN;
    end
  end
endmodule

// File: rtl/pz_digit_stage.sv
// Keeps one digit back until the following code shows whether it is last.
module pz_digit_stage
  import pz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_v,
  input  logic [NIB_W-1:0]  nib,
  input  nib_kind_e         kind,
  input  logic              first_nib,
  input  logic              out_free,
  output logic              advance,
  output logic              load,
  output logic [BYTE_W-1:0] load_data,
  output logic              load_last,
  output logic              err
);
  logic             pend_v;
  logic [NIB_W-1:0] pend_d;
  logic             needs_out;
  logic             bad;
  logic             err_base;

  assign needs_out = pend_v && (kind != NK_PAD);
  assign advance   = hold_v && (!needs_out || out_free);
  assign load      = advance && needs_out;
  assign load_last = (kind == NK_SIGN);
  assign load_data = {(kind == NK_SIGN) ? zone_for_sign(nib) : ZONE_DIGIT, pend_d};

  always_comb begin
    bad = 1'b0;
    if (kind == NK_DIGIT) bad = (nib > DIGIT_MAX);
    else if (kind == NK_SIGN) bad = !is_sign_code(nib) || !pend_v;
  end

  assign err_base = first_nib ? 1'b0 : err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_d <= '0;
      err    <= 1'b0;
    end else if (advance) begin
      err <= err_base | bad;
      if (kind == NK_DIGIT) begin
        pend_v <= 1'b1;
        pend_d <= nib;
      end else if (kind == NK_SIGN) begin
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pz_out_reg.sv
// Output register of the zoned stream; frozen while the consumer stalls.
module pz_out_reg
  import pz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              load_last,
  input  logic              out_ready,
  output logic              out_free,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  assign out_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_last  <= load_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pz_convert.sv
module pz_convert
  import pz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              err
);
  logic              advance;
  logic              hold_v;
  logic              hold_lo;
  logic [BYTE_W-1:0] hold_byte;
  logic              hold_last;
  logic              hold_first;
  logic [NIB_W-1:0]  nib;
  nib_kind_e         kind;
  logic              first_nib;
  logic              out_free;
  logic              load;
  logic [BYTE_W-1:0] load_data;
  logic              load_last;

  pz_byte_hold u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .advance(advance), .in_ready(in_ready),
    .hold_v(hold_v), .hold_lo(hold_lo), .hold_byte(hold_byte),
    .hold_last(hold_last), .hold_first(hold_first)
  );

  pz_nib_classify u_cls (
    .hold_lo(hold_lo), .hold_byte(hold_byte), .hold_last(hold_last),
    .hold_first(hold_first), .nib(nib), .kind(kind), .first_nib(first_nib)
  );

  pz_digit_stage u_dig (
    .clk(clk), .rst_n(rst_n), .hold_v(hold_v), .nib(nib), .kind(kind),
    .first_nib(first_nib), .out_free(out_free), .advance(advance),
    .load(load), .load_data(load_data), .load_last(load_last), .err(err)
  );

  pz_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .load_last(load_last), .out_ready(out_ready), .out_free(out_free),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/pz_convert_chk.sv
module pz_convert_chk
  import pz_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_data,
  input logic              out_last,
  input logic              err
);
  a_r9_stall_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r2_digit_zone: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_data[BYTE_W-1:NIB_W] == ZONE_DIGIT);

  a_r3_final_zone: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> (out_data[BYTE_W-1:NIB_W] == ZONE_DIGIT) ||
                              (out_data[BYTE_W-1:NIB_W] == SIGN_PLUS) ||
                              (out_data[BYTE_W-1:NIB_W] == SIGN_MINUS));

  a_r7_bad_digit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last && (out_data[NIB_W-1:0] > DIGIT_MAX) |-> err);
endmodule

bind pz_convert pz_convert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .err(err)
);

// File: tb/tb_pz_convert.sv
`timescale 1ns/1ps
module tb_pz_convert;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;
  logic       err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] ib [16];
  logic [7:0] eb [16];

  always #5 clk = ~clk;

  pz_convert dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode 0: free flow, 1: output stalls, 2: output stalls and input gaps
  task automatic run_case(input string req, input int n, input int ne,
                          input bit exp_err, input int mode);
    int ii = 0;
    int oi = 0;
    int cyc = 0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic prev_last = 1'b0;
    while ((ii < n || oi < ne) && cyc < 2000) begin
      @(negedge clk);
      in_valid  = (ii < n) && !(mode == 2 && cyc % 4 == 2);
      in_data   = (ii < n) ? ib[ii] : 8'h00;
      in_last   = (ii == n - 1);
      out_ready = !(mode >= 1 && cyc % 3 == 1);
      #2;
      if (prev_stall) begin
        chk(out_valid && out_data == prev_data && out_last == prev_last,
            {req, " R9 stall hold"}, int'(out_data), int'(prev_data));
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
      if (out_valid && out_ready) begin
        if (oi >= ne) begin
          chk(1'b0, {req, " extra byte"}, int'(out_data), 0);
        end else begin
          chk(out_data == eb[oi], {req, " data"}, int'(out_data), int'(eb[oi]));
          chk(out_last == (oi == ne - 1), {req, " R3 last flag"},
              int'(out_last), int'(oi == ne - 1));
        end
        oi++;
      end
      if (in_valid && in_ready) ii++;
      cyc++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk(ii == n && oi == ne, {req, " R10 counts"}, ii * 256 + oi, n * 256 + ne);
    chk(out_valid == 1'b0, {req, " no trailing byte"}, int'(out_valid), 0);
    chk(err == exp_err, {req, " R7 err"}, int'(err), int'(exp_err));
  endtask

  task automatic t_reset();
    #2;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(err == 1'b0, "R1 err", int'(err), 0);
  endtask

  task automatic t_odd_plus(input int mode);
    ib[0] = 8'h53; ib[1] = 8'h84; ib[2] = 8'h2C;
    eb[0] = 8'h35; eb[1] = 8'h33; eb[2] = 8'h38; eb[3] = 8'h34; eb[4] = 8'hC2;
    run_case("R4 R2 53842+", 3, 5, 1'b0, mode);
  endtask

  task automatic t_single_minus();
    ib[0] = 8'h7D; eb[0] = 8'hD7;
    run_case("R4 single 7-", 1, 1, 1'b0, 0);
  endtask

  task automatic t_sign_hi(input int mode);
    ib[0] = 8'h60; ib[1] = 8'h71; ib[2] = 8'hD0;
    eb[0] = 8'h36; eb[1] = 8'h30; eb[2] = 8'h37; eb[3] = 8'hD1;
    run_case("R5 6071-", 3, 4, 1'b0, mode);
  endtask

  task automatic t_lead_pad();
    ib[0] = 8'h01; ib[1] = 8'h23; ib[2] = 8'h4F;
    eb[0] = 8'h31; eb[1] = 8'h32; eb[2] = 8'h33; eb[3] = 8'h34;
    run_case("R6 R3 lead pad unsigned", 3, 4, 1'b0, 2);
  endtask

  task automatic t_single_zero();
    ib[0] = 8'h0C; eb[0] = 8'hC0;
    run_case("R6 single 0+", 1, 1, 1'b0, 1);
  endtask

  task automatic t_bad_digit();
    ib[0] = 8'h5A; ib[1] = 8'h3C;
    eb[0] = 8'h35; eb[1] = 8'h3A; eb[2] = 8'hC3;
    run_case("R7 bad digit", 2, 3, 1'b1, 1);
  endtask

  task automatic t_bad_sign();
    ib[0] = 8'h12; ib[1] = 8'h3B;
    eb[0] = 8'h31; eb[1] = 8'h32; eb[2] = 8'h33;
    run_case("R7 R11 bad sign", 2, 3, 1'b1, 0);
  endtask

  task automatic t_empty();
    ib[0] = 8'hC0;
    run_case("R8 no digits", 1, 0, 1'b1, 0);
  endtask

  task automatic t_err_clear();
    ib[0] = 8'h42; ib[1] = 8'h1F;
    eb[0] = 8'h34; eb[1] = 8'h32; eb[2] = 8'h31;
    run_case("R11 err clears", 2, 3, 1'b0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_odd_plus(0);
    t_single_minus();
    t_sign_hi(0);
    t_lead_pad();
    t_single_zero();
    t_bad_digit();
    t_err_clear();
    t_bad_sign();
    t_err_clear();
    t_empty();
    t_odd_plus(1);
    t_sign_hi(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule